// File: doc/BRIEF.md
# Path-Correlated Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of small saturating counters. The row for a branch comes from two parts joined together: a few low-order bits of the branch address on top, and a short register below them that records the directions of the most recently resolved branches. One branch address therefore owns one counter for each possible recent-outcome pattern. Two branches that differ only in address bits outside the index share counters. Nothing detects this sharing.

A fetch stage presents a branch address on the lookup side and receives the taken/not-taken guess in the same cycle. It also receives the outcome-history value that was used to form the guess, and it keeps that value with the branch. When the branch resolves, the execute stage returns the address, the real direction and that saved history value on the training side. At the next clock edge the selected counter moves one step toward the real direction. The real direction also enters the outcome register at its least significant end, and the oldest bit drops out.

Each counter works as a small state machine with four named zones: STRONG_NT (counter at zero), WEAK_NT (above zero, top bit clear), WEAK_T (top bit set, below maximum) and STRONG_T (at maximum). The named transitions are RISE (a taken outcome moves up one step, except in STRONG_T, which holds) and FALL (a not-taken outcome moves down one step, except in STRONG_NT, which holds). With the default 2-bit counters the zones are the values 0, 1, 2 and 3.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset, and whenever reset is asserted again, every counter holds the weak not-taken value 2^(CTR_W-1)-1, so every lookup predicts not-taken (pred_taken = 0), and the outcome register (pred_hist) is all zeros.
- R2: pred_taken is the most significant bit of the selected counter (1 = taken). It is valid in the same cycle as pred_pc, with no clock edge in between.
- R3: The counter index is {pc[IDX_LSB +: ADDR_IDX_W], history}, with the address bits in the upper part and the history bits in the lower part. The same address seen with different histories uses separate counters.
- R4: When upd_valid is high, the indexed counter rises by one on upd_taken = 1 and falls by one on upd_taken = 0. It holds at the maximum 2^CTR_W-1 and at zero.
- R5: With 2-bit counters, a counter at maximum needs two not-taken outcomes in a row before its prediction becomes not-taken. A counter at the weak not-taken reset value predicts taken after a single taken outcome.
- R6: When upd_valid is high, the next pred_hist is the previous one shifted left by one place, with upd_taken in bit 0 and the oldest bit dropped.
- R7: Training uses the index built from upd_pc and upd_hist, not from the current outcome register. A counter selected only by the current history is left unchanged.
- R8: If a lookup and a training update hit the same counter in the same cycle, the lookup returns the value from before the update.
- R9: pc bits below IDX_LSB and above IDX_LSB+ADDR_IDX_W-1 do not affect the index. Addresses that agree in the index bits share counters.
- R10: While upd_valid is low, no counter changes and pred_hist keeps its value, whatever upd_pc, upd_taken and upd_hist are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Direction guess: 1 = taken |
| pred_hist | output | HIST_W | Current outcome register, to be kept with the branch |
| upd_valid | input | 1 | Training request for this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real direction of the resolved branch |
| upd_hist | input | HIST_W | Outcome-register value saved when the branch was looked up |

## Verification
A guess is due in the same cycle as its address. The bench drives pred_pc on the falling edge and samples pred_taken and pred_hist one nanosecond later, before any rising edge. A training request takes effect at the next rising edge, so both the counter change and the history shift are read on the falling edge after that rising edge. The same-cycle case is sampled before that rising edge, which is how the pre-update value is checked. Every counter value is seen only through pred_taken, by steering pred_pc and the history so that they land on the counter under test.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;

    // Counter zones; the FSM of each counter is written over these.
    typedef enum logic [1:0] {
        STRONG_NT = 2'd0,
        WEAK_NT   = 2'd1,
        WEAK_T    = 2'd2,
        STRONG_T  = 2'd3
    } ctr_zone_e;

    // Transition taken by a counter on a training hit.
    typedef enum logic {
        FALL = 1'b0,
        RISE = 1'b1
    } ctr_move_e;

endpackage

// File: rtl/corr_bp_sat_ctr.sv
module corr_bp_sat_ctr
    import corr_bp_pkg::*;
#(
    parameter int CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             taken,
    output logic [CTR_W-1:0] cnt_o
);

    localparam logic [CTR_W-1:0] CNT_MAX  = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] CNT_ZERO = '0;
    localparam logic [CTR_W-1:0] CNT_RST  = CNT_MAX >> 1;

    logic [CTR_W-1:0] cnt_q;
    logic [CTR_W-1:0] cnt_d;
    ctr_zone_e        zone;
    ctr_move_e        move;

    // Classify the present value into a zone.
    always_comb begin
        if (cnt_q == CNT_ZERO) begin
            zone = STRONG_NT;
        end else if (cnt_q == CNT_MAX) begin
            zone = STRONG_T;
        end else if (cnt_q[CTR_W-1]) begin
            zone = WEAK_T;
        end else begin
            zone = WEAK_NT;
        end
    end

    assign move = taken ? RISE : FALL;

    // Next-state process.
    always_comb begin
        cnt_d = cnt_q;
        if (hit) begin
            unique case (zone)
                STRONG_NT: cnt_d = (move == RISE) ? cnt_q + 1'b1 : cnt_q;
                WEAK_NT:   cnt_d = (move == RISE) ? cnt_q + 1'b1 : cnt_q - 1'b1;
                WEAK_T:    cnt_d = (move == RISE) ? cnt_q + 1'b1 : cnt_q - 1'b1;
                STRONG_T:  cnt_d = (move == RISE) ? cnt_q : cnt_q - 1'b1;
                default:   cnt_d = cnt_q;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_RST;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Output process.
    always_comb begin
        cnt_o = cnt_q;
    end

endmodule

// File: rtl/corr_bp_ghist.sv
module corr_bp_ghist #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist_o
);

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;

    generate
        if (HIST_W == 1) begin : g_single
            always_comb begin
                hist_d = shift_en ? bit_in : hist_q;
            end
        end else begin : g_multi
            always_comb begin
                hist_d = shift_en ? {hist_q[HIST_W-2:0], bit_in} : hist_q;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist_o = hist_q;

endmodule

// File: rtl/corr_bp_table.sv
module corr_bp_table #(
    parameter int CTR_W     = 2,
    parameter int TBL_IDX_W = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [TBL_IDX_W-1:0]                 wr_idx,
    input  logic                                 wr_taken,
    output logic [(CTR_W << TBL_IDX_W)-1:0]      ctr_flat
);

    localparam int NUM_ENT = 1 << TBL_IDX_W;

    generate
        for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
            logic sel;
            assign sel = wr_en && (wr_idx == TBL_IDX_W'(e));
            corr_bp_sat_ctr #(
                .CTR_W (CTR_W)
            ) u_ctr (
                .clk   (clk),
                .rst_n (rst_n),
                .hit   (sel),
                .taken (wr_taken),
                .cnt_o (ctr_flat[e*CTR_W +: CTR_W])
            );
        end
    endgenerate

endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor #(
    parameter int PC_W       = 32,
    parameter int IDX_LSB    = 2,
    parameter int ADDR_IDX_W = 4,
    parameter int HIST_W     = 2,
    parameter int CTR_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] upd_hist
);

    localparam int TBL_IDX_W = ADDR_IDX_W + HIST_W;
    localparam int NUM_ENT   = 1 << TBL_IDX_W;

    logic [HIST_W-1:0]        ghist;
    logic [TBL_IDX_W-1:0]     pred_idx;
    logic [TBL_IDX_W-1:0]     upd_idx;
    logic [NUM_ENT*CTR_W-1:0] ctr_flat;
    logic [CTR_W-1:0]         pred_cnt;
    logic                     unused_pc_bits;

    // Address bits on top, outcome history below.
    assign pred_idx = {pred_pc[IDX_LSB +: ADDR_IDX_W], ghist};
    assign upd_idx  = {upd_pc[IDX_LSB +: ADDR_IDX_W], upd_hist};

    // Bits outside the index window do not take part.
    assign unused_pc_bits = ^{pred_pc, upd_pc};

    corr_bp_ghist #(
        .HIST_W (HIST_W)
    ) u_ghist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .bit_in   (upd_taken),
        .hist_o   (ghist)
    );

    corr_bp_table #(
        .CTR_W     (CTR_W),
        .TBL_IDX_W (TBL_IDX_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken),
        .ctr_flat (ctr_flat)
    );

    // Lookup reads the registered counters: pre-update on a same-cycle hit.
    assign pred_cnt   = ctr_flat[pred_idx*CTR_W +: CTR_W];
    assign pred_taken = pred_cnt[CTR_W-1];
    assign pred_hist  = ghist;

endmodule

// File: rtl/corr_bp_checker.sv
module corr_bp_checker #(
    parameter int PC_W      = 32,
    parameter int HIST_W    = 2,
    parameter int CTR_W     = 2,
    parameter int TBL_IDX_W = 6
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [PC_W-1:0]                  pred_pc,
    input logic                             pred_taken,
    input logic [HIST_W-1:0]                pred_hist,
    input logic                             upd_valid,
    input logic                             upd_taken,
    input logic [TBL_IDX_W-1:0]             upd_idx,
    input logic [(CTR_W << TBL_IDX_W)-1:0]  ctr_flat
);

    localparam logic [CTR_W-1:0]  CMAX     = {CTR_W{1'b1}};
    localparam logic [HIST_W-1:0] LOW_MASK = {HIST_W{1'b1}} >> 1;

    AST_HIST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> pred_hist[0] == $past(upd_taken)); // R6

    AST_HIST_SHIFT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (pred_hist >> 1) == ($past(pred_hist) & LOW_MASK)); // R6

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(pred_hist)); // R10

    AST_PRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> (!$stable(pred_pc) || $stable(pred_taken))); // R10

    AST_CTR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=>
        ctr_flat[$past(upd_idx)*CTR_W +: CTR_W] ==
        (($past(ctr_flat[upd_idx*CTR_W +: CTR_W]) == CMAX) ? CMAX :
         CTR_W'($past(ctr_flat[upd_idx*CTR_W +: CTR_W]) + 1'b1))); // R4

    AST_CTR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) |=>
        ctr_flat[$past(upd_idx)*CTR_W +: CTR_W] ==
        (($past(ctr_flat[upd_idx*CTR_W +: CTR_W]) == '0) ? CTR_W'(0) :
         CTR_W'($past(ctr_flat[upd_idx*CTR_W +: CTR_W]) - 1'b1))); // R4

endmodule

bind corr_branch_predictor corr_bp_checker #(
    .PC_W      (PC_W),
    .HIST_W    (HIST_W),
    .CTR_W     (CTR_W),
    .TBL_IDX_W (TBL_IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_pc    (pred_pc),
    .pred_taken (pred_taken),
    .pred_hist  (pred_hist),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .upd_idx    (upd_idx),
    .ctr_flat   (ctr_flat)
);

// File: tb/corr_branch_predictor_test.sv
`timescale 1ns/1ps
module corr_branch_predictor_test;

    localparam int PC_W = 32;
    localparam int HW   = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_taken;
    logic [HW-1:0]   pred_hist;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic [HW-1:0]   upd_hist = '0;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    corr_branch_predictor uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .pred_hist  (pred_hist),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken),
        .upd_hist   (upd_hist)
    );

    // {addr index[3:0], taken, expected guess, expected history after}
    localparam logic [7:0] VEC [16] = '{
        8'b00011001, 8'b00011011, 8'b00011011, 8'b00011111,
        8'b00011111, 8'b00010110, 8'b00100000, 8'b00100000,
        8'b00100000, 8'b00011101, 8'b00010110, 8'b00011001,
        8'b00011011, 8'b00010110, 8'b00010100, 8'b00011101
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [PC_W-1:0] pc_of(input logic [3:0] a);
        return PC_W'(a) << 2;
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                n_checks++;
                n_fails++;
                $display("FAIL watchdog all requirements actual=timeout expected=completion");
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        pred_pc = pc_of(4'd1);
        #1 check("R1 reset guess", pred_taken, 0);
        check("R1 reset history", pred_hist, 0);
        pred_pc = pc_of(4'd9);
        #1 check("R1 reset guess other entry", pred_taken, 0);

        // Vector walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            pred_pc = pc_of(VEC[i][7:4]);
            #1 check("R2 R3 R4 R5 vector guess", pred_taken, VEC[i][2]);
            upd_valid = 1'b1;
            upd_pc    = pc_of(VEC[i][7:4]);
            upd_taken = VEC[i][3];
            upd_hist  = pred_hist;
            @(negedge clk);
            upd_valid = 1'b0;
            #1 check("R6 vector history", pred_hist, VEC[i][1:0]);
        end
        // history now 01; counter (1,01)=2

        // R10: training requests with upd_valid low are ignored
        upd_pc = pc_of(4'd3); upd_taken = 1'b1; upd_hist = 2'b01;
        repeat (3) @(negedge clk);
        pred_pc = pc_of(4'd3);
        #1 check("R10 counter unchanged", pred_taken, 0);
        check("R10 history unchanged", pred_hist, 2'b01);
        pred_pc = pc_of(4'd1);
        #1 check("R10 trained entry kept", pred_taken, 1);

        // R9: bits outside the index window are ignored
        pred_pc = 32'hABC0_0007;
        #1 check("R9 alias shares entry", pred_taken, 1);
        pred_pc = pc_of(4'd5);
        #1 check("R9 different index", pred_taken, 0);

        // R7: training follows the saved history
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc_of(4'd4); upd_taken = 1'b1; upd_hist = 2'b10;
        @(negedge clk);
        upd_valid = 1'b0;
        pred_pc = pc_of(4'd4);
        #1 check("R7 current-history entry untouched", pred_taken, 0);
        check("R6 history after snapshot update", pred_hist, 2'b11);
        upd_valid = 1'b1; upd_pc = pc_of(4'd4); upd_taken = 1'b0; upd_hist = 2'b00;
        @(negedge clk);
        upd_valid = 1'b0;
        #1 check("R6 history shift", pred_hist, 2'b10);
        check("R7 R3 snapshot entry trained", pred_taken, 1);

        // R8: same-cycle lookup and update of one counter
        pred_pc = pc_of(4'd6);
        upd_valid = 1'b1; upd_pc = pc_of(4'd6); upd_taken = 1'b1; upd_hist = 2'b10;
        #1 check("R8 pre-update value", pred_taken, 0);
        @(negedge clk);
        upd_valid = 1'b0;
        // R5 second step: (6,10) now 2; one more lookup under history 10 via upd
        upd_valid = 1'b1; upd_pc = pc_of(4'd7); upd_taken = 1'b0; upd_hist = 2'b00;
        @(negedge clk);
        upd_valid = 1'b0;
        #1 check("R6 history after two shifts", pred_hist, 2'b10);
        check("R5 one taken flips weak counter", pred_taken, 1);

        // R1: reset asserted again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        pred_pc = pc_of(4'd1);
        #1 check("R1 re-reset history", pred_hist, 0);
        check("R1 re-reset guess", pred_taken, 0);

        finish_run();
    end

endmodule